// File: doc/BRIEF.md
# Pipelined Fixed-Point Color Space Converter

This block converts one three-component pixel per clock between gamma-corrected RGB and studio-range YCbCr. A direction input travels with each pixel. Direction 0 maps RGB to YCbCr. Direction 1 maps YCbCr back to RGB. The datapath is a constant-coefficient multiply-accumulate with about ten fractional bits, followed by round-half-up and clamping to the output width.

The pipeline has three register stages: an input register, one internal accumulator stage and an output register. A pixel appears at the outputs a fixed number of edges after it is captured, and the block never stalls. Component placement is symmetric. The upper byte of the 24-bit word is R in RGB form and Y in YCbCr form. The middle byte is G or Cb. The low byte is B or Cr. As a result, a forward result can be fed straight back in as a reverse input.

Top module: `csc_pipe`

## Requirements
- R1: With `in_mode`=0, the input is R=`in_pix[23:16]`, G=`[15:8]` and B=`[7:0]`. The output carries Y in `[23:16]`, Cb in `[15:8]` and Cr in `[7:0]`. Each output is a sum of three products plus an offset. Y uses 263·R + 516·G + 100·B + 16·1024. Cb uses −152·R − 298·G + 450·B + 128·1024. Cr uses 450·R − 377·G − 73·B + 128·1024.
- R2: With `in_mode`=1, the input is Y=`[23:16]`, Cb=`[15:8]` and Cr=`[7:0]`. The output carries R, G and B in the same byte positions. Let y=Y−16, u=Cb−128 and v=Cr−128. R uses 1192·y + 1634·v. G uses 1192·y − 401·u − 833·v. B uses 1192·y + 2065·u.
- R3: A pixel captured at rising edge n appears with `out_valid`=1 just after edge n+2, which is three register stages. `out_valid` is 1 only for cycles whose pixel was presented with `in_valid`=1.
- R4: A new pixel is accepted on every edge with no stall, so back-to-back valid pixels yield back-to-back results.
- R5: Each coefficient is the decimal weight times 1024, rounded to the nearest integer. The final sum is rounded by adding 512 and then shifting right arithmetically by 10, which floors the result.
- R6: A rounded result below 0 is output as 0, and a rounded result above 255 is output as 255.
- R7: The direction is captured with its own pixel. Changing `in_mode` from one cycle to the next affects only the pixel presented with it.
- R8: A synchronous `rst` clears every stage's valid flag, so `out_valid` is 0 on the cycle after a reset edge and any pixel in flight is dropped.
- R9: In direction 0, every output component lies in 16..240. An all-zero input gives Y=Cb=Cr in (16,128,128), and an all-255 input gives Y=235.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high, clears valid flags |
| in_valid | input | 1 | Qualifies `in_pix` and `in_mode` in this cycle |
| in_mode | input | 1 | 0 = RGB to YCbCr, 1 = YCbCr to RGB |
| in_pix | input | 3*DATA_W | Input pixel, component 0 in the top byte |
| out_valid | output | 1 | Qualifies `out_pix` |
| out_pix | output | 3*DATA_W | Converted pixel |

## Verification
The assertions assume a few things about the inputs. `in_valid` is held low while `rst` is high. The value of `in_mode` matters only in cycles where `in_valid` is high. Components are unsigned and fill the full byte range.

The range and neutral-black properties hold for any byte values, so the stimulus may use arbitrary random pixels without breaking them. The stimulus keeps `in_valid` low throughout every reset window. It mixes bubbles, direction flips on consecutive cycles and saturating chroma extremes, so that each property's antecedent is actually reached.

// File: rtl/csc_pkg.sv
package csc_pkg;

   typedef enum logic {
      CSC_TO_YCC = 1'b0,
      CSC_TO_RGB = 1'b1
   } csc_dir_e;

   localparam int CSC_NCH = 3;

   // weights in thousandths; row = output channel, col = input channel
   function automatic int milli_coef(input bit to_rgb, input int row, input int col);
      int k;
      k = 0;
      if (!to_rgb) begin
         case (row * 3 + col)
            0: k = 257;
            1: k = 504;
            2: k = 98;
            3: k = -148;
            4: k = -291;
            5: k = 439;
            6: k = 439;
            7: k = -368;
            8: k = -71;
            default: k = 0;
         endcase
      end else begin
         case (row * 3 + col)
            0: k = 1164;
            1: k = 0;
            2: k = 1596;
            3: k = 1164;
            4: k = -392;
            5: k = -813;
            6: k = 1164;
            7: k = 2017;
            8: k = 0;
            default: k = 0;
         endcase
      end
      return k;
   endfunction

   // nearest-integer scaling of a thousandths weight to 2^frac
   function automatic int scale_coef(input int milli, input int frac);
      int mag;
      int s;
      mag = (milli < 0) ? -milli : milli;
      s   = (mag * (1 << frac) + 500) / 1000;
      return (milli < 0) ? -s : s;
   endfunction

   // offset removed from an input channel, at 8-bit scale
   function automatic int in_bias8(input bit to_rgb, input int col);
      if (!to_rgb) return 0;
      return (col == 0) ? 16 : 128;
   endfunction

   // offset added to an output channel, at 8-bit scale
   function automatic int out_bias8(input bit to_rgb, input int row);
      if (to_rgb) return 0;
      return (row == 0) ? 16 : 128;
   endfunction

endpackage

// File: rtl/csc_mac.sv
module csc_mac #(
   parameter int DATA_W = 8,
   parameter int FRAC   = 10,
   parameter int ROW    = 0,
   parameter int ACC_W  = 24
) (
   input  logic                       to_rgb,
   input  logic [3*DATA_W-1:0]        px,
   output logic signed [ACC_W-1:0]    acc
);
   import csc_pkg::*;

   localparam int CW = FRAC + 4;
   localparam int DW = DATA_W + 2;
   localparam int SH = DATA_W - 8;
   localparam logic signed [ACC_W-1:0] OB_FWD =
      ACC_W'((out_bias8(1'b0, ROW) << SH) << FRAC);
   localparam logic signed [ACC_W-1:0] ACC_ZERO = '0;

   for (genvar c = 0; c < CSC_NCH; c++) begin : g_col
      localparam logic signed [CW-1:0] K_FWD = CW'(scale_coef(milli_coef(1'b0, ROW, c), FRAC));
      localparam logic signed [CW-1:0] K_REV = CW'(scale_coef(milli_coef(1'b1, ROW, c), FRAC));
      localparam logic signed [DW-1:0] B_REV = DW'(in_bias8(1'b1, c) << SH);
      localparam logic signed [DW-1:0] B_NONE = '0;

      logic [DATA_W-1:0]        x;
      logic signed [DW-1:0]     d;
      logic signed [CW-1:0]     k;
      logic signed [ACC_W-1:0]  t;

      always_comb begin
         x = px[(CSC_NCH-1-c)*DATA_W +: DATA_W];
         d = $signed({2'b00, x}) - (to_rgb ? B_REV : B_NONE);
         k = to_rgb ? K_REV : K_FWD;
         t = ACC_W'(d) * ACC_W'(k);
      end
   end

   always_comb begin
      acc = g_col[0].t + g_col[1].t + g_col[2].t + (to_rgb ? ACC_ZERO : OB_FWD);
   end

endmodule

// File: rtl/csc_round_sat.sv
module csc_round_sat #(
   parameter int ACC_W  = 24,
   parameter int FRAC   = 10,
   parameter int DATA_W = 8
) (
   input  logic signed [ACC_W-1:0] acc,
   output logic [DATA_W-1:0]       q
);
   localparam logic signed [ACC_W-1:0] HALF =
      {{(ACC_W-FRAC){1'b0}}, 1'b1, {(FRAC-1){1'b0}}};
   localparam logic signed [ACC_W-1:0] MAXV =
      {{(ACC_W-DATA_W){1'b0}}, {DATA_W{1'b1}}};

   logic signed [ACC_W-1:0] biased;
   logic signed [ACC_W-1:0] whole;

   always_comb begin
      biased = acc + HALF;
      whole  = biased >>> FRAC;
      if (whole[ACC_W-1]) begin
         q = '0;
      end else if (whole > MAXV) begin
         q = '1;
      end else begin
         q = whole[DATA_W-1:0];
      end
   end

endmodule

// File: rtl/csc_pipe.sv
module csc_pipe #(
   parameter int DATA_W = 8,
   parameter int FRAC   = 10
) (
   input  logic                  clk,
   input  logic                  rst,
   input  logic                  in_valid,
   input  logic                  in_mode,
   input  logic [3*DATA_W-1:0]   in_pix,
   output logic                  out_valid,
   output logic [3*DATA_W-1:0]   out_pix
);
   import csc_pkg::*;

   localparam int PIX_W = CSC_NCH * DATA_W;
   localparam int ACC_W = DATA_W + FRAC + 6;
   localparam int SH    = DATA_W - 8;

   if (DATA_W < 8 || DATA_W > 12) begin : g_bad_data_w
      $error("csc_pipe: DATA_W must lie in 8..12");
   end
   if (FRAC < 2 || FRAC > 16) begin : g_bad_frac
      $error("csc_pipe: FRAC must lie in 2..16");
   end

   // stage 0: input register
   logic              v0;
   csc_dir_e          m0;
   logic [PIX_W-1:0]  p0;

   always_ff @(posedge clk) begin
      if (rst) v0 <= 1'b0;
      else     v0 <= in_valid;
   end

   always_ff @(posedge clk) begin
      if (in_valid) begin
         m0 <= csc_dir_e'(in_mode);
         p0 <= in_pix;
      end
   end

   // stage 1: accumulator register; stage 2: output register
   logic      v1;
   csc_dir_e  m1;
   csc_dir_e  m2;

   always_ff @(posedge clk) begin
      if (rst) begin
         v1        <= 1'b0;
         out_valid <= 1'b0;
      end else begin
         v1        <= v0;
         out_valid <= v1;
      end
   end

   always_ff @(posedge clk) begin
      if (v0) m1 <= m0;
      if (v1) m2 <= m1;
   end

   for (genvar r = 0; r < CSC_NCH; r++) begin : g_ch
      logic signed [ACC_W-1:0] a_d;
      logic signed [ACC_W-1:0] a_q;
      logic [DATA_W-1:0]       q_d;
      logic [DATA_W-1:0]       o_q;

      csc_mac #(
         .DATA_W (DATA_W),
         .FRAC   (FRAC),
         .ROW    (r),
         .ACC_W  (ACC_W)
      ) i_mac (
         .to_rgb (m0 == CSC_TO_RGB),
         .px     (p0),
         .acc    (a_d)
      );

      always_ff @(posedge clk) begin
         if (v0) a_q <= a_d;
      end

      csc_round_sat #(
         .ACC_W  (ACC_W),
         .FRAC   (FRAC),
         .DATA_W (DATA_W)
      ) i_rs (
         .acc (a_q),
         .q   (q_d)
      );

      always_ff @(posedge clk) begin
         if (v1) o_q <= q_d;
      end
   end

   assign out_pix = {g_ch[0].o_q, g_ch[1].o_q, g_ch[2].o_q};

   // ---------------- assertions ----------------
   localparam logic [DATA_W-1:0] FWD_LO = DATA_W'(16 << SH);
   localparam logic [DATA_W-1:0] FWD_HI = DATA_W'(240 << SH);
   localparam logic [PIX_W-1:0]  NEUTRAL =
      {DATA_W'(16 << SH), DATA_W'(128 << SH), DATA_W'(128 << SH)};

   // R3: a valid result traces back to a valid pixel three edges earlier
   p_valid_lat_r3: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> $past(in_valid, 3));

   // R7: the direction at the output is the one given with that pixel
   p_mode_held_r7: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> (m2 == csc_dir_e'($past(in_mode, 3))));

   // R8: a reset edge leaves no valid result behind it
   p_reset_clear_r8: assert property (@(posedge clk)
      rst |=> !out_valid);

   // R9: forward results stay inside the studio range
   p_fwd_range_r9: assert property (@(posedge clk) disable iff (rst)
      (out_valid && m2 == CSC_TO_YCC) |->
         (out_pix[3*DATA_W-1:2*DATA_W] >= FWD_LO && out_pix[3*DATA_W-1:2*DATA_W] <= FWD_HI &&
          out_pix[2*DATA_W-1:DATA_W]   >= FWD_LO && out_pix[2*DATA_W-1:DATA_W]   <= FWD_HI &&
          out_pix[DATA_W-1:0]          >= FWD_LO && out_pix[DATA_W-1:0]          <= FWD_HI));

   // R2: neutral YCbCr maps to black
   p_neutral_black_r2: assert property (@(posedge clk) disable iff (rst)
      (out_valid && $past(in_valid && in_mode && (in_pix == NEUTRAL), 3)) |->
         (out_pix == '0));

endmodule

// File: tb/test_csc_pipe.sv
`timescale 1ns/1ps
module test_csc_pipe;

   logic        clk = 1'b0;
   logic        rst;
   logic        in_valid;
   logic        in_mode;
   logic [23:0] in_pix;
   logic        out_valid;
   logic [23:0] out_pix;

   always #2 clk = ~clk;

   csc_pipe i_csc_pipe (
      .clk       (clk),
      .rst       (rst),
      .in_valid  (in_valid),
      .in_mode   (in_mode),
      .in_pix    (in_pix),
      .out_valid (out_valid),
      .out_pix   (out_pix)
   );

   int    n_cmp = 0;
   int    n_bad = 0;
   bit    done  = 1'b0;
   bit          qv[$];
   logic [23:0] qd[$];
   string       qt[$];

   function automatic int rnd_clamp(input int a);
      int t;
      t = (a + 512) >>> 10;
      if (t < 0)   t = 0;
      if (t > 255) t = 255;
      return t;
   endfunction

   // integer reference built from R1, R2, R5, R6
   function automatic logic [23:0] model(input bit rev, input logic [23:0] p);
      int a, b, c, o0, o1, o2;
      a = int'(p[23:16]);
      b = int'(p[15:8]);
      c = int'(p[7:0]);
      if (!rev) begin
         o0 = rnd_clamp(263*a + 516*b + 100*c + 16*1024);
         o1 = rnd_clamp(-152*a - 298*b + 450*c + 128*1024);
         o2 = rnd_clamp(450*a - 377*b - 73*c + 128*1024);
      end else begin
         a = a - 16; b = b - 128; c = c - 128;
         o0 = rnd_clamp(1192*a + 1634*c);
         o1 = rnd_clamp(1192*a - 401*b - 833*c);
         o2 = rnd_clamp(1192*a + 2065*b);
      end
      return {o0[7:0], o1[7:0], o2[7:0]};
   endfunction

   task automatic pop_check();
      bit          ev;
      logic [23:0] ed;
      string       et;
      ev = qv.pop_front();
      ed = qd.pop_front();
      et = qt.pop_front();
      n_cmp++;
      if (out_valid !== ev) begin
         n_bad++;
         $display("FAIL %s valid: actual %b expected %b", et, out_valid, ev);
      end else if (ev && out_pix !== ed) begin
         n_bad++;
         $display("FAIL %s data: actual %06h expected %06h", et, out_pix, ed);
      end
   endtask

   task automatic prefill();
      qv.delete(); qd.delete(); qt.delete();
      for (int i = 0; i < 3; i++) begin
         qv.push_back(1'b0); qd.push_back('0); qt.push_back("R3");
      end
   endtask

   task automatic step(input bit v, input bit m, input logic [23:0] p, input string tag);
      @(negedge clk);
      pop_check();
      in_valid = v;
      in_mode  = m;
      in_pix   = p;
      qv.push_back(v);
      qd.push_back(model(m, p));
      qt.push_back(tag);
   endtask

   task automatic reset_and_check(input string tag);
      @(negedge clk);
      rst      = 1'b1;
      in_valid = 1'b0;
      @(negedge clk);
      n_cmp++;
      if (out_valid !== 1'b0) begin
         n_bad++;
         $display("FAIL %s reset valid: actual %b expected 0", tag, out_valid);
      end
      rst = 1'b0;
      prefill();
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
   endtask

   initial begin
      rst = 1'b1; in_valid = 1'b0; in_mode = 1'b0; in_pix = '0;
      repeat (3) @(posedge clk);
      reset_and_check("R8");

      // R1 forward corners, R9 range endpoints
      step(1, 0, 24'h000000, "R9");
      step(1, 0, 24'hFFFFFF, "R9");
      step(1, 0, 24'hFF0000, "R1");
      step(1, 0, 24'h00FF00, "R1");
      step(1, 0, 24'h0000FF, "R1");
      // R2 reverse, neutral and white
      step(1, 1, 24'h108080, "R2");
      step(1, 1, 24'hEB8080, "R2");
      // R6 saturating chroma extremes
      step(1, 1, 24'h101010, "R6");
      step(1, 1, 24'hFFFFFF, "R6");
      step(1, 1, 24'h000000, "R6");
      step(1, 1, 24'h10F010, "R6");
      step(1, 1, 24'h1010F0, "R6");
      step(1, 1, 24'hFFF0F0, "R6");
      // R3 bubbles between valid pixels
      for (int i = 0; i < 40; i++)
         step(i % 3 == 0, 1'(i % 2), 24'($urandom), "R3");
      // R7 direction flips every cycle
      for (int i = 0; i < 400; i++)
         step(1, 1'(i % 2), 24'($urandom), "R7");
      // R5 random forward, back-to-back
      for (int i = 0; i < 600; i++)
         step(1, 0, 24'($urandom), "R5");
      // R4 random mixed, no gaps
      for (int i = 0; i < 600; i++)
         step(1, 1'($urandom), 24'($urandom), "R4");
      // R2 random reverse with sparse gaps
      for (int i = 0; i < 400; i++)
         step(($urandom % 8) != 0, 1, 24'($urandom), "R2");
      // R8 reset with pixels in flight
      step(1, 0, 24'h123456, "R8");
      step(1, 1, 24'h80FF00, "R8");
      reset_and_check("R8");
      for (int i = 0; i < 6; i++)
         step(1, 1'(i % 2), 24'($urandom), "R1");
      for (int i = 0; i < 4; i++)
         step(0, 0, 24'h0, "R3");
      done = 1'b1;
      summary();
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL R3 watchdog: actual not finished expected finished");
         summary();
         $finish;
      end
   end

endmodule